// File: doc/BRIEF.md
# Two-Outcome History Branch Predictor

This block is the direction guess for a fetch stage. It holds a direct-mapped table of small per-entry histories, selected by low bits of the program counter. Each entry keeps the real outcomes of the last two branches that resolved into it. A combinational function turns the history into a taken or not-taken guess for the address being fetched. Entries carry no tag, so branches whose addresses alias onto the same row share one history.

When a branch resolves later in the pipeline, its address and real outcome come in on the resolve port. One clock edge later the outcome has been shifted into the selected row. A fetch lookup in the same cycle as a write to the same row returns the contents from before the write. The block predicts direction only. Target addresses and misprediction recovery belong to neighbouring logic.

Top module: `branchHistPredictor`

## Requirements
- R1: With a row history of 2'b11, 2'b01 or 2'b10, the guess `predTaken` is 1. History bit 1 is the older outcome, bit 0 is the newer one, and 1 means taken.
- R2: With a row history of 2'b00, the guess `predTaken` is 0.
- R3: While reset is asserted, and after it is released, every row reads 2'b00 until it is written.
- R4: A resolve with `resolveValid`=1 changes the selected row at the next clock edge to {older = previous newer, newer = `resolveTaken`}.
- R5: The row is selected by PC bits [11:2] on both ports. Addresses that differ only in bits [1:0] or in bits above 11 share one row.
- R6: A fetch lookup in the same cycle as a resolve to the same row returns the history from before that write. The new value is visible from the next cycle onward.
- R7: When `resolveValid` is 0, `resolvePc` and `resolveTaken` change no row.
- R8: A resolve changes only its own row. Every other row, including row 0x3FF at the top of the table, keeps its history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | 32 | Address being fetched |
| predTaken | output | 1 | Direction guess for fetchPc (1 = taken) |
| fetchHistory | output | 2 | Row history for fetchPc, {older, newer} |
| resolveValid | input | 1 | A resolved branch is presented this cycle |
| resolvePc | input | 32 | Address of the resolved branch |
| resolveTaken | input | 1 | Real outcome of the resolved branch (1 = taken) |

## Verification
Aliasing is the hardest situation to reach from the ports. Exposing it needs two different addresses that collide on bits [11:2], with one of them writing the row and the other reading it back. The vector table sends writes through an address that differs in the low byte bits, and another that differs above bit 11, then reads the row through the base address. It also reads and writes the same row in one cycle to expose the pre-write value. Row 0x3FF and row 0 are written against each other to show that the index wraps cleanly at the top of the table.

// File: rtl/bhtPkg.sv
package bhtPkg;

  // One row of the history table: two recorded outcomes, 1 = taken.
  typedef struct packed {
    logic older;
    logic newer;
  } histT;

  localparam histT HIST_INIT = '{older: 1'b0, newer: 1'b0};

  // Strobes from the control module to the table datapath.
  typedef struct packed {
    logic wrEn;
    logic wrTaken;
  } ctrlStrobeT;

endpackage

// File: rtl/bhtCtrl.sv
module bhtCtrl
  import bhtPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 10
) (
  input  logic [PC_W-1:0]  fetchPc,
  input  logic             resolveValid,
  input  logic [PC_W-1:0]  resolvePc,
  input  logic             resolveTaken,
  output logic [IDX_W-1:0] rdIdx,
  output logic [IDX_W-1:0] wrIdx,
  output ctrlStrobeT       strobe
);

  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  // Bits that play no part in row selection (aliasing is intended).
  logic unusedPcBits;
  assign unusedPcBits = ^{fetchPc[PC_W-1:IDX_HI+1], fetchPc[IDX_LO-1:0],
                          resolvePc[PC_W-1:IDX_HI+1], resolvePc[IDX_LO-1:0]};

  always_comb begin
    rdIdx          = fetchPc[IDX_HI:IDX_LO];
    wrIdx          = resolvePc[IDX_HI:IDX_LO];
    strobe.wrEn    = resolveValid;
    strobe.wrTaken = resolveValid & resolveTaken;
  end

endmodule

// File: rtl/bhtTable.sv
module bhtTable
  import bhtPkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output histT             rdHist
);

  localparam int DEPTH = 1 << IDX_W;

  logic [2*DEPTH-1:0] histFlat;

  for (genvar i = 0; i < DEPTH; i++) begin : gRow
    histT rowQ;
    logic rowHit;
    assign rowHit = strobe.wrEn && (wrIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rowQ <= HIST_INIT;
      end else if (rowHit) begin
        rowQ <= '{older: rowQ.newer, newer: strobe.wrTaken};
      end
    end

    assign histFlat[2*i +: 2] = rowQ;
  end

  // Read path comes straight from the registers: it shows pre-write contents.
  assign rdHist = histT'(histFlat[2*rdIdx +: 2]);

endmodule

// File: rtl/bhtPredictFn.sv
module bhtPredictFn
  import bhtPkg::*;
(
  input  histT hist,
  output logic taken
);

  // Guess not-taken only when both recorded outcomes were not-taken.
  always_comb begin
    unique case ({hist.older, hist.newer})
      2'b00:   taken = 1'b0;
      default: taken = 1'b1;
    endcase
  end

endmodule

// File: rtl/branchHistPredictor.sv
module branchHistPredictor
  import bhtPkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  output logic [1:0]      fetchHistory,
  input  logic            resolveValid,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken
);

  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;
  ctrlStrobeT       strobe;
  histT             rdHist;

  bhtCtrl #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) uCtrl (
    .fetchPc      (fetchPc),
    .resolveValid (resolveValid),
    .resolvePc    (resolvePc),
    .resolveTaken (resolveTaken),
    .rdIdx        (rdIdx),
    .wrIdx        (wrIdx),
    .strobe       (strobe)
  );

  bhtTable #(.IDX_W(IDX_W)) uTable (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrIdx  (wrIdx),
    .rdIdx  (rdIdx),
    .rdHist (rdHist)
  );

  bhtPredictFn uPredict (
    .hist  (rdHist),
    .taken (predTaken)
  );

  assign fetchHistory = rdHist;

endmodule

// File: rtl/bhtChecker.sv
module bhtChecker #(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] fetchPc,
  input logic            predTaken,
  input logic [1:0]      fetchHistory,
  input logic            resolveValid,
  input logic [PC_W-1:0] resolvePc,
  input logic            resolveTaken
);

  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0] fIdx;
  logic [IDX_W-1:0] rIdx;
  logic             sameRow;
  assign fIdx    = fetchPc[IDX_HI:IDX_LO];
  assign rIdx    = resolvePc[IDX_HI:IDX_LO];
  assign sameRow = (fIdx == rIdx);

  // R3: rows read empty while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_empty_R3: assert (fetchHistory == 2'b00 && !predTaken);
    end
  end

  // R4, R6: the watched row shifts in the resolved outcome one edge later
  assert_shift_update_R4: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid && sameRow |=>
      (fIdx != $past(fIdx)) ||
      (fetchHistory == {$past(fetchHistory[0]), $past(resolveTaken)}));

  // R7: without a valid resolve the watched row does not move
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |=> (fIdx != $past(fIdx)) || $stable(fetchHistory));

  // R8: a resolve to another row leaves the watched row alone
  assert_other_row_R8: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid && !sameRow |=> (fIdx != $past(fIdx)) || $stable(fetchHistory));

  // R1: a taken outcome just written makes the row guess taken
  assert_taken_after_T_R1: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid && resolveTaken && sameRow |=>
      (fIdx != $past(fIdx)) || predTaken);

  // R2: a row reading empty history guesses not-taken after a not-taken write
  assert_nt_guess_R2: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid && !resolveTaken && sameRow && (fetchHistory[0] == 1'b0) |=>
      (fIdx != $past(fIdx)) || !predTaken);

endmodule

bind branchHistPredictor bhtChecker #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .fetchPc      (fetchPc),
  .predTaken    (predTaken),
  .fetchHistory (fetchHistory),
  .resolveValid (resolveValid),
  .resolvePc    (resolvePc),
  .resolveTaken (resolveTaken)
);

// File: tb/tb_branchHistPredictor.sv
module tb_branchHistPredictor;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] fetchPc;
  logic        predTaken;
  logic [1:0]  fetchHistory;
  logic        resolveValid;
  logic [31:0] resolvePc;
  logic        resolveTaken;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  branchHistPredictor dut (
    .clk          (clk),
    .rstN         (rstN),
    .fetchPc      (fetchPc),
    .predTaken    (predTaken),
    .fetchHistory (fetchHistory),
    .resolveValid (resolveValid),
    .resolvePc    (resolvePc),
    .resolveTaken (resolveTaken)
  );

  typedef struct packed {
    logic        rv;
    logic [31:0] rpc;
    logic        rt;
    logic [31:0] fpc;
    logic        expPred;
    logic [1:0]  expHist;
    logic [23:0] tag;
  } vecT;

  // Row A = 0x040 via 0x100; 0x103 and 0x1100 alias to it. Row B = 0x041.
  localparam int NV = 19;
  localparam vecT VECS [NV] = '{
    '{1'b0, 32'h0,      1'b0, 32'h100,  1'b0, 2'b00, "R3 "},
    '{1'b1, 32'h100,    1'b1, 32'h100,  1'b0, 2'b00, "R6 "},
    '{1'b0, 32'h0,      1'b0, 32'h100,  1'b1, 2'b01, "R4 "},
    '{1'b1, 32'h100,    1'b0, 32'h100,  1'b1, 2'b01, "R6 "},
    '{1'b0, 32'h0,      1'b0, 32'h100,  1'b1, 2'b10, "R1 "},
    '{1'b1, 32'h103,    1'b1, 32'h104,  1'b0, 2'b00, "R8 "},
    '{1'b0, 32'h0,      1'b0, 32'h1100, 1'b1, 2'b01, "R5 "},
    '{1'b1, 32'h1100,   1'b1, 32'h100,  1'b1, 2'b01, "R5 "},
    '{1'b0, 32'h0,      1'b0, 32'h100,  1'b1, 2'b11, "R1 "},
    '{1'b1, 32'h100,    1'b0, 32'h104,  1'b0, 2'b00, "R8 "},
    '{1'b1, 32'h100,    1'b0, 32'h100,  1'b1, 2'b10, "R4 "},
    '{1'b0, 32'h0,      1'b0, 32'h100,  1'b0, 2'b00, "R2 "},
    '{1'b0, 32'h100,    1'b1, 32'h100,  1'b0, 2'b00, "R7 "},
    '{1'b0, 32'h0,      1'b0, 32'h100,  1'b0, 2'b00, "R7 "},
    '{1'b1, 32'h104,    1'b1, 32'h100,  1'b0, 2'b00, "R8 "},
    '{1'b0, 32'h0,      1'b0, 32'h104,  1'b1, 2'b01, "R4 "},
    '{1'b1, 32'hFFC,    1'b1, 32'h0,    1'b0, 2'b00, "R8 "},
    '{1'b0, 32'h0,      1'b0, 32'hFFC,  1'b1, 2'b01, "R8 "},
    '{1'b0, 32'h0,      1'b0, 32'h1000, 1'b0, 2'b00, "R5 "}
  };

  task automatic check(input logic [23:0] tag, input logic expPred, input logic [1:0] expHist);
    applied++;
    if (predTaken !== expPred || fetchHistory !== expHist) begin
      miscompares++;
      $display("FAIL %s: pred=%b hist=%b expected pred=%b hist=%b",
               tag, predTaken, fetchHistory, expPred, expHist);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    fetchPc = 32'h100;
    resolveValid = 1'b0;
    resolvePc = 32'h0;
    resolveTaken = 1'b0;
    repeat (3) @(negedge clk);
    #5 check("R3 ", 1'b0, 2'b00);   // R3 during reset
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      resolveValid = VECS[i].rv;
      resolvePc    = VECS[i].rpc;
      resolveTaken = VECS[i].rt;
      fetchPc      = VECS[i].fpc;
      #5 check(VECS[i].tag, VECS[i].expPred, VECS[i].expHist);
    end

    // R3: reset mid-run clears written rows A, B and 0x3FF
    @(negedge clk);
    resolveValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    fetchPc = 32'h100;
    #5 check("R3 ", 1'b0, 2'b00);
    @(negedge clk); fetchPc = 32'h104;
    #5 check("R3 ", 1'b0, 2'b00);
    @(negedge clk); fetchPc = 32'hFFC;
    #5 check("R3 ", 1'b0, 2'b00);

    // R6: back-to-back writes to one row, each read sees the older value
    @(negedge clk);
    resolveValid = 1'b1; resolvePc = 32'h200; resolveTaken = 1'b1; fetchPc = 32'h200;
    #5 check("R6 ", 1'b0, 2'b00);
    @(negedge clk); resolveTaken = 1'b1;
    #5 check("R6 ", 1'b1, 2'b01);
    @(negedge clk); resolveValid = 1'b0;
    #5 check("R1 ", 1'b1, 2'b11);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule